// File: doc/BRIEF.md
# Dual-Task Scaler Scheduler

This block decides when a video scaler works, and which of two programmed task settings it uses. Each task has its own enable, a start condition, a repeat flag, a field-skip count and a vertical and horizontal window origin with a window height. The scheduler watches the raster position counters, the vertical sync pulse and the field identifier. It activates one task at a time, and then hands control to the other task when the window ends.

Start conditions are checked only while a task is armed. A task is armed after its skip count has been used up. The task fires on the exact cycle that the raster reaches its window origin. Each firing gives a one-cycle start pulse and inverts a toggle flag. Downstream logic uses the toggle flag to rebuild interlaced output when the field rate is reduced. Enables are read only at the end of a task. An active-low software reset returns everything to idle at once. Task B is chosen first after any reset.

Top module: `twin_task_sched`

## Requirements
- R1: When `rst` is high or `sw_rst_n` is low at a clock edge, the block goes idle after that edge: `task_busy`=0, `task_start`=0, `toggle`=0 and `active_sel`=1.
- R2: `active_sel` encodes task A as 0 and task B as 1. When leaving idle with both tasks enabled, task B is chosen.
- R3: Start code 0 fires as soon as the armed task's origin is reached. Start code 1 fires at the origin only if a `vsync` pulse came after the task was armed.
- R4: Start code 2 fires at the origin only while `fid`=0. Start code 3 fires at the origin only while `fid`=1.
- R5: A task fires only on a cycle where `vcnt` equals its vertical origin and `hcnt` equals its horizontal origin. If the position is already past the origin, nothing fires until the origin comes round again.
- R6: With a skip count N>0, the task stays pending for N `vsync` pulses before it is armed. No firing happens while it is pending.
- R7: A task with its repeat bit set runs twice in a row before control passes to the other enabled task.
- R8: `task_start` is high for exactly one cycle, in the cycle after the firing edge. `task_busy` stays high from then until the task ends. A task ends when `vcnt` is at least origin plus height, or when `vsync` arrives.
- R9: `toggle` inverts on every activation and changes at no other time except at reset. It does not follow `fid`.
- R10: Enables are read only at the end of a task. Clearing an enable during a run neither stops the run nor changes `active_sel`.
- R11: At the end of a task (with no repeat pending), the other task is chosen if it is enabled. Otherwise the same task is chosen again if it is enabled. Otherwise the block goes idle and does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst_n | input | 1 | Synchronous active-low software reset |
| vsync | input | 1 | Single-cycle vertical sync pulse |
| fid | input | 1 | Field identifier level |
| hcnt | input | HW | Horizontal position |
| vcnt | input | VW | Vertical position |
| task_en | input | 2 | Enables, bit 0 = A, bit 1 = B |
| task_cond | input | 4 | Start codes, [1:0] = A, [3:2] = B |
| task_rpt | input | 2 | Repeat flags, bit 0 = A, bit 1 = B |
| task_skip | input | 2*SKW | Field-skip counts, low slice = A |
| task_voff | input | 2*VW | Vertical origins, low slice = A |
| task_hoff | input | 2*HW | Horizontal origins, low slice = A |
| task_vlen | input | 2*VW | Window heights, low slice = A |
| active_sel | output | 1 | Selected task, 0 = A, 1 = B |
| task_start | output | 1 | One-cycle activation pulse |
| task_busy | output | 1 | High while a task runs |
| toggle | output | 1 | Inverts on every activation |

## Verification
The arbitration is tried in three ways: with both tasks enabled, with only one enabled, and with enables cleared during a run. This separates the choice of the other task, the fallback to the same task, the idle case and the rule that enables are read only at the end of a task. Each start code is driven to the origin twice: once with its qualifier missing (no prior `vsync`, or the wrong `fid`) and once with it present. This shows that the gating works, not just the position match. Positions one pixel past the origin, pending skip counts and the repeat flag separate an exact-origin trigger from a threshold trigger, and a counted skip from a single wait.

// File: rtl/twin_task_pkg.sv
package twin_task_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ARM  = 2'd2,
    ST_RUN  = 2'd3
  } sched_state_t;

  typedef enum logic [1:0] {
    COND_NOW   = 2'd0,
    COND_VSYNC = 2'd1,
    COND_FID0  = 2'd2,
    COND_FID1  = 2'd3
  } start_cond_t;

  localparam int NUM_TASKS = 2;
  localparam int COND_W    = 2;

endpackage

// File: rtl/tt_trigger.sv
module tt_trigger
  import twin_task_pkg::*;
#(
  parameter int VW = 12,
  parameter int HW = 12
) (
  input  logic [COND_W-1:0] cond_i,
  input  logic [VW-1:0]     voff_i,
  input  logic [HW-1:0]     hoff_i,
  input  logic [VW-1:0]     vlen_i,
  input  logic [VW-1:0]     vcnt_i,
  input  logic [HW-1:0]     hcnt_i,
  input  logic              fid_i,
  input  logic              vs_seen_i,
  output logic              fire_o,
  output logic              win_done_o
);

  localparam int EW = VW + 1;

  logic          at_origin;
  logic [EW-1:0] end_line;

  assign at_origin = (vcnt_i == voff_i) && (hcnt_i == hoff_i);
  assign end_line  = {1'b0, voff_i} + {1'b0, vlen_i};

  always_comb begin
    unique case (start_cond_t'(cond_i))
      COND_NOW:   fire_o = at_origin;
      COND_VSYNC: fire_o = at_origin && vs_seen_i;
      COND_FID0:  fire_o = at_origin && !fid_i;
      COND_FID1:  fire_o = at_origin && fid_i;
      default:    fire_o = 1'b0;
    endcase
  end

  assign win_done_o = ({1'b0, vcnt_i} >= end_line);

endmodule

// File: rtl/tt_skip_ctr.sv
module tt_skip_ctr #(
  parameter int SKW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           load,
  input  logic [SKW-1:0] load_val,
  input  logic           dec_en,
  input  logic           vsync,
  output logic           cnt_zero
);

  logic [SKW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec_en && vsync && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cnt_zero = (cnt == '0);

  AST_SKIP_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (($past(cnt) == '0) && !$past(load)) |-> (cnt == '0)); // R6

endmodule

// File: rtl/twin_task_sched.sv
module twin_task_sched
  import twin_task_pkg::*;
#(
  parameter int VW  = 12,
  parameter int HW  = 12,
  parameter int SKW = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sw_rst_n,
  input  logic                       vsync,
  input  logic                       fid,
  input  logic [HW-1:0]              hcnt,
  input  logic [VW-1:0]              vcnt,
  input  logic [NUM_TASKS-1:0]       task_en,
  input  logic [NUM_TASKS*COND_W-1:0] task_cond,
  input  logic [NUM_TASKS-1:0]       task_rpt,
  input  logic [NUM_TASKS*SKW-1:0]   task_skip,
  input  logic [NUM_TASKS*VW-1:0]    task_voff,
  input  logic [NUM_TASKS*HW-1:0]    task_hoff,
  input  logic [NUM_TASKS*VW-1:0]    task_vlen,
  output logic                       active_sel,
  output logic                       task_start,
  output logic                       task_busy,
  output logic                       toggle
);

  localparam logic SEL_A = 1'b0;
  localparam logic SEL_B = 1'b1;

  sched_state_t         state;
  logic                 rep_done;
  logic                 vs_seen;
  logic [NUM_TASKS-1:0] fire_v;
  logic [NUM_TASKS-1:0] done_v;
  logic                 skip_zero;

  // per-task trigger evaluation
  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_task
    tt_trigger #(.VW(VW), .HW(HW)) u_trig (
      .cond_i     (task_cond[i*COND_W +: COND_W]),
      .voff_i     (task_voff[i*VW +: VW]),
      .hoff_i     (task_hoff[i*HW +: HW]),
      .vlen_i     (task_vlen[i*VW +: VW]),
      .vcnt_i     (vcnt),
      .hcnt_i     (hcnt),
      .fid_i      (fid),
      .vs_seen_i  (vs_seen),
      .fire_o     (fire_v[i]),
      .win_done_o (done_v[i])
    );
  end

  // next-task decision
  logic           any_en;
  logic           idle_pick;
  logic           other;
  logic           nxt_ok;
  logic           nxt_sel;
  logic           nxt_rep;
  logic           run_end;
  logic           launch;
  logic           launch_sel;
  logic [SKW-1:0] launch_skip;

  always_comb begin
    any_en    = |task_en;
    idle_pick = task_en[SEL_B] ? SEL_B : SEL_A;
    other     = ~active_sel;
    if (task_rpt[active_sel] && !rep_done && task_en[active_sel]) begin
      nxt_ok  = 1'b1;
      nxt_sel = active_sel;
      nxt_rep = 1'b1;
    end else if (task_en[other]) begin
      nxt_ok  = 1'b1;
      nxt_sel = other;
      nxt_rep = 1'b0;
    end else if (task_en[active_sel]) begin
      nxt_ok  = 1'b1;
      nxt_sel = active_sel;
      nxt_rep = 1'b0;
    end else begin
      nxt_ok  = 1'b0;
      nxt_sel = active_sel;
      nxt_rep = 1'b0;
    end
    run_end     = (state == ST_RUN) && (done_v[active_sel] || vsync);
    launch      = ((state == ST_IDLE) && any_en) || (run_end && nxt_ok);
    launch_sel  = (state == ST_IDLE) ? idle_pick : nxt_sel;
    launch_skip = task_skip[int'(launch_sel)*SKW +: SKW];
  end

  tt_skip_ctr #(.SKW(SKW)) u_skip (
    .clk      (clk),
    .rst      (rst),
    .clr      (!sw_rst_n),
    .load     (launch),
    .load_val (launch_skip),
    .dec_en   (state == ST_PEND),
    .vsync    (vsync),
    .cnt_zero (skip_zero)
  );

  // scheduler state machine
  always_ff @(posedge clk) begin
    if (rst || !sw_rst_n) begin
      state      <= ST_IDLE;
      active_sel <= SEL_B;
      rep_done   <= 1'b0;
      vs_seen    <= 1'b0;
      task_start <= 1'b0;
      task_busy  <= 1'b0;
      toggle     <= 1'b0;
    end else begin
      task_start <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            active_sel <= launch_sel;
            rep_done   <= 1'b0;
            vs_seen    <= 1'b0;
            state      <= (launch_skip != '0) ? ST_PEND : ST_ARM;
          end
        end
        ST_PEND: begin
          if (skip_zero) begin
            state   <= ST_ARM;
            vs_seen <= 1'b0;
          end
        end
        ST_ARM: begin
          if (vsync) vs_seen <= 1'b1;
          if (fire_v[active_sel]) begin
            state      <= ST_RUN;
            task_start <= 1'b1;
            task_busy  <= 1'b1;
            toggle     <= ~toggle;
          end
        end
        ST_RUN: begin
          if (run_end) begin
            task_busy <= 1'b0;
            if (nxt_ok) begin
              active_sel <= nxt_sel;
              rep_done   <= nxt_rep;
              vs_seen    <= 1'b0;
              state      <= (launch_skip != '0) ? ST_PEND : ST_ARM;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    task_start |=> !task_start); // R8

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    task_start |-> task_busy); // R8

  AST_TOGGLE_ON_START: assert property (@(posedge clk) disable iff (rst)
    (toggle != $past(toggle)) |-> (task_start || !toggle)); // R9

  AST_SEL_HELD_IN_RUN: assert property (@(posedge clk) disable iff (rst || !sw_rst_n)
    (task_busy && $past(task_busy)) |-> $stable(active_sel)); // R10

  AST_SWRST_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sw_rst_n |=> (!task_busy && !toggle && active_sel)); // R1

endmodule

// File: tb/test_twin_task_sched.sv
`timescale 1ns/1ps
module test_twin_task_sched;

  localparam int VW  = 12;
  localparam int HW  = 12;
  localparam int SKW = 3;

  localparam int A_V = 20, A_H = 5, A_L = 10;
  localparam int B_V = 40, B_H = 8, B_L = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sw_rst_n = 1'b1;
  logic              vsync = 1'b0;
  logic              fid = 1'b0;
  logic [HW-1:0]     hcnt = '0;
  logic [VW-1:0]     vcnt = '0;
  logic [1:0]        task_en = '0;
  logic [3:0]        task_cond = '0;
  logic [1:0]        task_rpt = '0;
  logic [2*SKW-1:0]  task_skip = '0;
  logic [2*VW-1:0]   task_voff;
  logic [2*HW-1:0]   task_hoff;
  logic [2*VW-1:0]   task_vlen;
  logic              active_sel;
  logic              task_start;
  logic              task_busy;
  logic              toggle;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  assign task_voff = {12'(B_V), 12'(A_V)};
  assign task_hoff = {12'(B_H), 12'(A_H)};
  assign task_vlen = {12'(B_L), 12'(A_L)};

  twin_task_sched #(.VW(VW), .HW(HW), .SKW(SKW)) i_twin_task_sched (
    .clk(clk), .rst(rst), .sw_rst_n(sw_rst_n), .vsync(vsync), .fid(fid),
    .hcnt(hcnt), .vcnt(vcnt), .task_en(task_en), .task_cond(task_cond),
    .task_rpt(task_rpt), .task_skip(task_skip), .task_voff(task_voff),
    .task_hoff(task_hoff), .task_vlen(task_vlen), .active_sel(active_sel),
    .task_start(task_start), .task_busy(task_busy), .toggle(toggle)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_pos(input int v, input int h);
    vcnt = VW'(v);
    hcnt = HW'(h);
    step(1);
  endtask

  task automatic park();
    go_pos(0, 0);
  endtask

  task automatic pulse_vs();
    vsync = 1'b1;
    step(1);
    vsync = 1'b0;
  endtask

  task automatic do_reset();
    task_en = '0; task_cond = '0; task_rpt = '0; task_skip = '0;
    fid = 1'b0; vsync = 1'b0; vcnt = '0; hcnt = '0; sw_rst_n = 1'b1;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "sel after reset", int'(active_sel), 1);
    chk("R1", "busy after reset", int'(task_busy), 0);
    chk("R1", "start after reset", int'(task_start), 0);
    chk("R1", "toggle after reset", int'(toggle), 0);
  endtask

  task automatic t_priority();
    do_reset();
    task_en = 2'b11;
    step(1);
    go_pos(B_V, B_H);
    chk("R2", "B first sel", int'(active_sel), 1);
    chk("R8", "start pulse", int'(task_start), 1);
    chk("R9", "toggle after 1st", int'(toggle), 1);
    park();
    chk("R8", "start drops", int'(task_start), 0);
    chk("R8", "busy holds", int'(task_busy), 1);
    go_pos(B_V + B_L, 0);
    chk("R8", "busy ends", int'(task_busy), 0);
    chk("R11", "other task chosen", int'(active_sel), 0);
    park();
    go_pos(A_V, A_H);
    chk("R11", "A fires", int'(task_start), 1);
    chk("R9", "toggle after 2nd", int'(toggle), 0);
  endtask

  task automatic t_position();
    do_reset();
    task_en = 2'b01;
    step(1);
    go_pos(A_V, A_H + 1);
    step(2);
    chk("R5", "past origin no fire", int'(task_busy), 0);
    go_pos(A_V - 1, A_H);
    chk("R5", "wrong line no fire", int'(task_busy), 0);
    go_pos(A_V, A_H);
    chk("R3", "code0 fires at origin", int'(task_start), 1);
    go_pos(A_V + A_L, 0);
    chk("R8", "end at origin+height", int'(task_busy), 0);
    park();
    go_pos(A_V, A_H);
    chk("R11", "same task again", int'(task_start), 1);
    chk("R11", "same task sel", int'(active_sel), 0);
  endtask

  task automatic t_vsync_cond();
    do_reset();
    task_en = 2'b01;
    task_cond = 4'b0001;
    step(1);
    go_pos(A_V, A_H);
    chk("R3", "code1 without vsync", int'(task_busy), 0);
    park();
    pulse_vs();
    go_pos(A_V, A_H);
    chk("R3", "code1 after vsync", int'(task_start), 1);
    park();
    pulse_vs();
    chk("R8", "vsync ends run", int'(task_busy), 0);
  endtask

  task automatic t_fid();
    do_reset();
    task_en = 2'b01;
    task_cond = 4'b0010;
    step(1);
    fid = 1'b1;
    go_pos(A_V, A_H);
    chk("R4", "code2 with fid=1", int'(task_busy), 0);
    fid = 1'b0;
    go_pos(A_V, A_H);
    chk("R4", "code2 with fid=0", int'(task_start), 1);
    do_reset();
    task_en = 2'b10;
    task_cond = 4'b1100;
    step(1);
    fid = 1'b0;
    go_pos(B_V, B_H);
    chk("R4", "code3 with fid=0", int'(task_busy), 0);
    fid = 1'b1;
    go_pos(B_V, B_H);
    chk("R4", "code3 with fid=1", int'(task_start), 1);
    chk("R9", "toggle ignores fid", int'(toggle), 1);
  endtask

  task automatic t_skip();
    do_reset();
    task_en = 2'b01;
    task_skip = 6'(2);
    step(1);
    go_pos(A_V, A_H);
    chk("R6", "pending no fire 0", int'(task_busy), 0);
    park();
    pulse_vs();
    step(1);
    go_pos(A_V, A_H);
    chk("R6", "pending no fire 1", int'(task_busy), 0);
    park();
    pulse_vs();
    step(1);
    go_pos(A_V, A_H);
    chk("R6", "fires after 2 vsync", int'(task_start), 1);
  endtask

  task automatic t_repeat();
    do_reset();
    task_en = 2'b11;
    task_rpt = 2'b10;
    step(1);
    go_pos(B_V, B_H);
    chk("R7", "B first run", int'(task_start), 1);
    go_pos(B_V + B_L, 0);
    chk("R7", "B kept for repeat", int'(active_sel), 1);
    park();
    go_pos(B_V, B_H);
    chk("R7", "B repeat run", int'(task_start), 1);
    go_pos(B_V + B_L, 0);
    chk("R7", "A after repeat", int'(active_sel), 0);
    park();
    go_pos(A_V, A_H);
    chk("R7", "A runs", int'(task_start), 1);
  endtask

  task automatic t_enable();
    do_reset();
    task_en = 2'b11;
    step(1);
    go_pos(B_V, B_H);
    chk("R10", "B running", int'(task_busy), 1);
    task_en = 2'b00;
    park();
    step(2);
    chk("R10", "run survives disable", int'(task_busy), 1);
    chk("R10", "sel unchanged", int'(active_sel), 1);
    go_pos(B_V + B_L, 0);
    chk("R10", "ends at window", int'(task_busy), 0);
    park();
    go_pos(B_V, B_H);
    go_pos(A_V, A_H);
    chk("R11", "idle no fire", int'(task_busy), 0);
  endtask

  task automatic t_swreset();
    do_reset();
    task_en = 2'b11;
    step(1);
    go_pos(B_V + 0, B_H);
    park();
    go_pos(B_V + B_L, 0);
    park();
    go_pos(A_V, A_H);
    chk("R9", "toggle before swrst", int'(toggle), 0);
    go_pos(A_V + A_L, 0);
    park();
    go_pos(B_V, B_H);
    chk("R9", "third activation", int'(toggle), 1);
    sw_rst_n = 1'b0;
    step(1);
    sw_rst_n = 1'b1;
    chk("R1", "swrst busy", int'(task_busy), 0);
    chk("R1", "swrst toggle", int'(toggle), 0);
    chk("R1", "swrst sel", int'(active_sel), 1);
    park();
    go_pos(B_V, B_H);
    chk("R2", "B after swrst", int'(task_start), 1);
    chk("R2", "B sel after swrst", int'(active_sel), 1);
  endtask

  logic finished = 1'b0;

  initial begin
    t_reset();
    t_priority();
    t_position();
    t_vsync_cond();
    t_fid();
    t_skip();
    t_repeat();
    t_enable();
    t_swreset();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule